// File: doc/BRIEF.md
# CSR-Driven Fast Pin Bank

This block gives a processor core a small bank of pins that software drives through control-and-status register (CSR) accesses instead of a memory-mapped peripheral. Each access names a CSR address and one of four operations: read only, write, set or clear. A single set or clear changes only the chosen bits of the output latch, with no read-modify-write in software, so one instruction toggles a pin.

There are eight output channels and eight input channels. Three CSRs are decoded: an output-enable mask, a read-only view of the synchronised input levels, and the output latch. Input lines come from the pad routing and pass through a two-flop synchronizer before software sees them. An access to any other address is flagged as illegal during the same cycle and reads as zero. Pad multiplexing, interrupts and privilege checks are left to the surrounding logic.

The read data is combinational from the current state, so the value returned is the one held before the access's own update. Output changes appear on the pins after the clock edge that ends the access.

Top module: `csr_pinbank`

## Requirements
- R1: After reset the output latch, the output-enable mask and both synchronizer stages are zero, so `pin_out`, `pin_oe` and a read of the input CSR all give zero.
- R2: Address 0x803 selects the output-enable CSR, 0x804 the input CSR and 0x805 the output CSR; `csr_op` encodes 0 = read only, 1 = write, 2 = set, 3 = clear; a read returns the CSR value in bits 7:0 and zero in bits 31:8, and nothing changes while `csr_valid` is low.
- R3: A write to 0x805 replaces all eight latch bits with operand bits 7:0; `pin_out` shows the latch whatever the enable mask, and a read of 0x805 returns the latch, not the input pins.
- R4: A set on 0x805 ORs operand bits 7:0 into the latch; a clear on 0x805 clears each latch bit whose operand bit is 1.
- R5: The output-enable CSR at 0x803 takes write, set and clear the same way as the output latch, and `pin_oe` follows it bit for bit.
- R6: A read of 0x804 returns in bits 7:0 the levels that `pin_in` held just before the clock edge two edges earlier.
- R7: A write, set or clear to 0x804 changes neither the output latch nor the enable mask.
- R8: An access with `csr_valid` high to any address other than 0x803, 0x804 or 0x805 drives `csr_illegal` high in that cycle, returns zero and changes no state; `csr_illegal` is low in every other cycle.
- R9: An update becomes visible on `pin_out`/`pin_oe` after the clock edge that ends the access; the read data in the access cycle is the old value.
- R10: Operand bits 31:8 have no effect on either writable CSR.
- R11: A masked update done as a set with M&V followed by a clear with M&~V leaves latch bits outside M unchanged and sets bits inside M to V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | CSR access present this cycle |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | 32 | Operand for write, set or clear |
| csr_rdata | output | 32 | Read data, value before this access |
| csr_illegal | output | 1 | Access to an undecoded address this cycle |
| pin_out | output | 8 | Output latch driven toward the pads |
| pin_oe | output | 8 | Per-channel output enable |
| pin_in | input | 8 | Input levels from the pad routing |

## Verification
Read data and the illegal flag are due in the same cycle as the access, pin and enable changes one edge later, and input levels two edges after they are applied. The bench keeps a behavioural model that it advances exactly once per clock edge and compares every output against the model at the falling edge, after inputs for the cycle are settled and before the next rising edge, so each result is checked in the cycle it is due and never earlier.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    localparam int unsigned ADDR_W   = 12;
    localparam logic [ADDR_W-1:0] ADR_OE  = 12'h803;
    localparam logic [ADDR_W-1:0] ADR_IN  = 12'h804;
    localparam logic [ADDR_W-1:0] ADR_OUT = 12'h805;

    typedef struct packed {
        logic oe;
        logic inp;
        logic outv;
        logic bad;
    } sel_t;

endpackage

// File: rtl/pb_decode.sv
module pb_decode
    import pb_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [AW-1:0] addr,
    output sel_t          sel
);

    always_comb begin
        sel = '0;
        if (valid) begin
            unique case (addr)
                AW'(ADR_OE):  sel.oe   = 1'b1;
                AW'(ADR_IN):  sel.inp  = 1'b1;
                AW'(ADR_OUT): sel.outv = 1'b1;
                default:      sel.bad  = 1'b1;
            endcase
        end
    end

    // R2
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $countones({sel.oe, sel.inp, sel.outv, sel.bad}) == 1);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> sel == '0);

endmodule

// File: rtl/pb_chanreg.sv
module pb_chanreg
    import pb_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  op_e           op,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  q
);

    localparam int unsigned USED = (W < DW) ? W : DW;

    logic [W-1:0] operand;
    assign operand = W'(wdata[USED-1:0]);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (hit) begin
                unique case (op)
                    OP_WRITE: q[i] <= operand[i];
                    OP_SET:   if (operand[i]) q[i] <= 1'b1;
                    OP_CLEAR: if (operand[i]) q[i] <= 1'b0;
                    default:  ;
                endcase
            end
        end
    end

    // R4
    set_ors_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_SET) |=> ((q & $past(operand)) == $past(operand))
                                  && ((q & ~$past(operand)) == ($past(q) & ~$past(operand))));

    // R4
    clear_ands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_CLEAR) |=> ((q & $past(operand)) == '0)
                                    && ((q & ~$past(operand)) == ($past(q) & ~$past(operand))));

    // R3
    write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_WRITE) |=> q == $past(operand));

    // R7
    no_touch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && op != OP_READ) |=> $stable(q));

endmodule

// File: rtl/pb_sync.sv
module pb_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/csr_pinbank.sv
module csr_pinbank
    import pb_pkg::*;
#(
    parameter int unsigned CH = 8,
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_valid,
    input  logic [AW-1:0] csr_addr,
    input  logic [1:0]    csr_op,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    output logic          csr_illegal,
    output logic [CH-1:0] pin_out,
    output logic [CH-1:0] pin_oe,
    input  logic [CH-1:0] pin_in
);

    sel_t         sel;
    op_e          op;
    logic [CH-1:0] in_sync;
    logic [CH-1:0] out_q;
    logic [CH-1:0] oe_q;

    assign op = op_e'(csr_op);

    pb_decode #(.AW(AW)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (csr_valid),
        .addr  (csr_addr),
        .sel   (sel)
    );

    pb_chanreg #(.W(CH), .DW(DW)) u_outlat (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (sel.outv),
        .op    (op),
        .wdata (csr_wdata),
        .q     (out_q)
    );

    pb_chanreg #(.W(CH), .DW(DW)) u_oemask (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (sel.oe),
        .op    (op),
        .wdata (csr_wdata),
        .q     (oe_q)
    );

    pb_sync #(.W(CH), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_sync)
    );

    always_comb begin
        csr_rdata = '0;
        unique case (1'b1)
            sel.oe:   csr_rdata = DW'(oe_q);
            sel.inp:  csr_rdata = DW'(in_sync);
            sel.outv: csr_rdata = DW'(out_q);
            default:  csr_rdata = '0;
        endcase
    end

    assign csr_illegal = sel.bad;
    assign pin_out     = out_q;
    assign pin_oe      = oe_q;

    // R8
    illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == '0);

    // R8
    illegal_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> $stable(pin_out) && $stable(pin_oe));

    // R7
    input_csr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_addr == AW'(ADR_IN)) |=> $stable(pin_out) && $stable(pin_oe));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[DW-1:CH] == '0);

endmodule

// File: tb/csr_pinbank_tb_top.sv
module csr_pinbank_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_in = '0;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [7:0] m_out = '0;
    logic [7:0] m_oe = '0;
    logic [7:0] m_hist [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_pinbank dut_i (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] apply(logic [7:0] cur, logic [1:0] op, logic [7:0] v);
        case (op)
            2'd1:    return v;
            2'd2:    return cur | v;
            2'd3:    return cur & ~v;
            default: return cur;
        endcase
    endfunction

    // one access cycle: drive, compare, advance model, take the edge
    task automatic cyc(bit v, logic [11:0] a, logic [1:0] op, logic [31:0] d, logic [7:0] pin, string tag);
        logic [31:0] exp_rd;
        bit          exp_bad;
        @(negedge clk);
        csr_valid = v; csr_addr = a; csr_op = op; csr_wdata = d; pin_in = pin;
        #1;
        exp_bad = v && !(a == 12'h803 || a == 12'h804 || a == 12'h805);
        exp_rd  = 32'h0;
        if (v && a == 12'h803) exp_rd = {24'h0, m_oe};
        if (v && a == 12'h804) exp_rd = {24'h0, m_hist[0]};
        if (v && a == 12'h805) exp_rd = {24'h0, m_out};
        check(tag, "rdata", csr_rdata, exp_rd);
        check("R8", "illegal", {31'h0, csr_illegal}, {31'h0, exp_bad});
        check("R3", "pin_out", {24'h0, pin_out}, {24'h0, m_out});
        check("R5", "pin_oe", {24'h0, pin_oe}, {24'h0, m_oe});
        if (v && a == 12'h805) m_out = apply(m_out, op, d[7:0]);
        if (v && a == 12'h803) m_oe  = apply(m_oe, op, d[7:0]);
        // input history: [0] is visible level, [1] is first stage
        m_hist.push_back(pin);
        void'(m_hist.pop_front());
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        m_hist.push_back(8'h00);
        m_hist.push_back(8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "reset pin_out", {24'h0, pin_out}, 32'h0);
        check("R1", "reset pin_oe", {24'h0, pin_oe}, 32'h0);
        rst_n = 1'b1;
        cyc(1, 12'h804, 2'd0, 0, 8'h00, "R1");
        cyc(1, 12'h805, 2'd0, 0, 8'h00, "R1");
        // R3: full write, ignores oe; R9 read shows old value
        cyc(1, 12'h805, 2'd1, 32'h0000_00A5, 8'h00, "R3");
        cyc(1, 12'h805, 2'd0, 0, 8'h5A, "R9");
        // R4: set (low channels, immediate style) and clear
        cyc(1, 12'h805, 2'd2, 32'h0000_000F, 8'h00, "R4");
        cyc(1, 12'h805, 2'd3, 32'h0000_0081, 8'h00, "R4");
        cyc(1, 12'h805, 2'd0, 0, 8'h00, "R4");
        // R10: upper operand bits ignored
        cyc(1, 12'h805, 2'd1, 32'hFFFF_FF3C, 8'h00, "R10");
        cyc(1, 12'h805, 2'd2, 32'hABCD_0000, 8'h00, "R10");
        cyc(1, 12'h805, 2'd0, 0, 8'h00, "R10");
        // R5: output-enable write/set/clear
        cyc(1, 12'h803, 2'd1, 32'h0000_00F0, 8'h00, "R5");
        cyc(1, 12'h803, 2'd2, 32'h0000_0003, 8'h00, "R5");
        cyc(1, 12'h803, 2'd3, 32'h0000_0090, 8'h00, "R5");
        cyc(1, 12'h803, 2'd0, 0, 8'h00, "R5");
        // R6: input synchronizer latency with changing pins
        for (int k = 0; k < 12; k++)
            cyc(1, 12'h804, 2'd0, 0, 8'(k * 37 + 5), "R6");
        // R7: writes to input CSR ignored
        cyc(1, 12'h804, 2'd1, 32'h0000_00FF, 8'h11, "R7");
        cyc(1, 12'h804, 2'd2, 32'h0000_00FF, 8'h22, "R7");
        cyc(1, 12'h804, 2'd3, 32'h0000_00FF, 8'h33, "R7");
        cyc(1, 12'h805, 2'd0, 0, 8'h44, "R7");
        cyc(1, 12'h803, 2'd0, 0, 8'h44, "R7");
        // R8: illegal addresses
        cyc(1, 12'h806, 2'd1, 32'h0000_00FF, 8'h00, "R8");
        cyc(1, 12'h000, 2'd2, 32'h0000_00FF, 8'h00, "R8");
        cyc(1, 12'h802, 2'd3, 32'h0000_00FF, 8'h00, "R8");
        cyc(1, 12'h805, 2'd0, 0, 8'h00, "R8");
        // R2: no effect when valid is low
        cyc(0, 12'h805, 2'd1, 32'h0000_0000, 8'h00, "R2");
        cyc(0, 12'h803, 2'd3, 32'h0000_00FF, 8'h00, "R2");
        cyc(1, 12'h803, 2'd0, 0, 8'h00, "R2");
        // R11: masked update M=0x3C V=0x14
        cyc(1, 12'h805, 2'd1, 32'h0000_00C3, 8'h00, "R11");
        cyc(1, 12'h805, 2'd2, 32'h0000_0014, 8'h00, "R11");
        cyc(1, 12'h805, 2'd3, 32'h0000_0028, 8'h00, "R11");
        cyc(1, 12'h805, 2'd0, 0, 8'h00, "R11");
        // explicit end value for R11: outside mask 0xC3 kept, inside = 0x14
        @(negedge clk);
        check("R11", "masked result", {24'h0, pin_out}, 32'h0000_00D7);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule